// File: doc/BRIEF.md
# Safety Fault Flag Register Bank

This block gathers fault indications from many independent monitors (supply, clock, digital integrity and serial-link monitors) and keeps them as active-low status flags that a host reads through a small register interface. A flag reads 1 while all is well and 0 once its monitor has reported a fault. The block also holds a monitor-enable bit and a diagnostic-enable bit for each monitor of the supply, clock and digital classes. A diagnostic-enable forces the monitor's fault path active, so the host can prove that the flag can still fall.

Two recovery policies coexist. Supply, clock and digital flags, and the reset indicator, are sticky: they stay low until the host writes a 1 to the bit, and the clear has no effect while the fault is still asserted. The four serial-link flags (frame checksum error, link timeout, clock-edge count error, illegal register access) ignore host writes. They return to 1 on their own when a serial frame ends without any link fault. A counter word holds one 2-bit completion counter for each converter.

Top module: `fault_flag_bank`

## Requirements
- R1: After reset, every supply, clock and digital flag and every link flag reads 1, all completion counters read 0, and every enable, diagnostic-enable and link-enable register reads 0.
- R2: A supply, clock or digital monitor whose enable bit is 0 never drives its flag to 0, whatever its fault input or diagnostic bit.
- R3: Once a supply, clock or digital flag is 0 it stays 0 until a host clear of that bit.
- R4: Writing a status word (supply at address 2, clock at 3, digital at 4) clears every flag whose written bit is 1 and leaves flags written with 0 untouched. If the flag's enabled fault is active in the same cycle, the fault wins and the flag stays 0.
- R5: With both its enable and diagnostic-enable set, a flag reads 0 from the clock edge that samples that setting, even with the fault input low.
- R6: A link fault whose link-enable bit (address 11: bit0 checksum, bit1 timeout, bit2 edge count, bit3 access) is 1 drives its flag to 0 at the next edge. Host writes to the general word never set a link flag.
- R7: At a frame-end strobe, if no enabled link fault was seen since the previous frame end (the strobe cycle included), all four link flags return to 1. Otherwise each flag keeps its value and a new frame begins.
- R8: The reset indicator (general word, bit 0) reads 0 after every reset and stays 0 until the host writes 1 to bit 0 of address 0.
- R9: Each converter has a 2-bit counter at bits [2i+1:2i] of address 1. It advances by one for each cycle its completion input is high and wraps from 3 to 0.
- R10: Reads are combinational from the read address. Address 0 holds the reset indicator at bit0 and the link flags at bits [4:1] (checksum, timeout, edge count, access). Addresses 5/6/7 hold the supply/clock/digital enables, 8/9/10 the diagnostic-enables and 11 the link-enables, all writable and read back. Addresses 12 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 4 | Host write address |
| wr_data_i | input | 16 | Host write data (clear mask or register value) |
| rd_addr_i | input | 4 | Host read address |
| rd_data_o | output | 16 | Read data for rd_addr_i |
| sup_fault_i | input | N_SUP | Supply monitor fault levels, active high |
| clk_fault_i | input | N_CLK | Clock monitor fault levels, active high |
| dig_fault_i | input | N_DIG | Digital integrity fault levels, active high |
| comm_fault_i | input | 4 | Link fault pulses: checksum, timeout, edge count, access |
| frame_end_i | input | 1 | One-cycle strobe at the end of each serial frame |
| conv_done_i | input | N_CONV | One-cycle completion pulse per converter |

## Verification
The sticky flags are swept through many combinations of enable, diagnostic-enable and fault patterns that differ from bit to bit. This separates the enable gating, diagnostic forcing and fault-over-clear priority per bit position, and shows whether partial clear masks and zero writes are honoured. The link flags are driven frame by frame with clean frames, faulty frames, faults in the frame-end cycle and partly enabled links, which separates recovery after a clean frame from holding after a faulty one. The counters get gray-like pulse patterns long enough to wrap each lane several times, and a second reset in mid-run with state latched shows that the reset indicator and all defaults return.

// File: rtl/ffb_pkg.sv
package ffb_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int N_COMM = 4;

    localparam logic [ADDR_W-1:0] A_GEN     = 4'd0;
    localparam logic [ADDR_W-1:0] A_CONV    = 4'd1;
    localparam logic [ADDR_W-1:0] A_SUP_ST  = 4'd2;
    localparam logic [ADDR_W-1:0] A_CLK_ST  = 4'd3;
    localparam logic [ADDR_W-1:0] A_DIG_ST  = 4'd4;
    localparam logic [ADDR_W-1:0] A_SUP_EN  = 4'd5;
    localparam logic [ADDR_W-1:0] A_CLK_EN  = 4'd6;
    localparam logic [ADDR_W-1:0] A_DIG_EN  = 4'd7;
    localparam logic [ADDR_W-1:0] A_SUP_DG  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CLK_DG  = 4'd9;
    localparam logic [ADDR_W-1:0] A_DIG_DG  = 4'd10;
    localparam logic [ADDR_W-1:0] A_COMM_EN = 4'd11;
endpackage

// File: rtl/ffb_sticky_group.sv
module ffb_sticky_group #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] diag_i,
    input  logic [W-1:0] fault_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_no
);
    typedef struct packed {
        logic [W-1:0] flag_n;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] hit;

    always_comb begin
        hit         = en_i & (fault_i | diag_i);
        st_d        = st_q;
        st_d.flag_n = (st_q.flag_n | clr_i) & ~hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{flag_n: '1};
        else         st_q <= st_d;
    end

    assign flag_no = st_q.flag_n;

    AST_ENABLED_FAULT_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> ((flag_no & $past(en_i & (fault_i | diag_i))) == '0)); // R5
    AST_LOW_STAYS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> ((flag_no & ~$past(flag_no) & ~$past(clr_i)) == '0)); // R3
    AST_NO_FALL_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> ((~flag_no & $past(flag_no) & ~$past(en_i & (fault_i | diag_i))) == '0)); // R2
endmodule

// File: rtl/ffb_comm_group.sv
module ffb_comm_group
    import ffb_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_COMM-1:0] comm_en_i,
    input  logic [N_COMM-1:0] comm_fault_i,
    input  logic              frame_end_i,
    input  logic              rst_clr_i,
    output logic              rst_flag_no,
    output logic [N_COMM-1:0] comm_flag_no
);
    typedef struct packed {
        logic              rst_flag_n;
        logic [N_COMM-1:0] comm_flag_n;
        logic [N_COMM-1:0] seen;
    } state_t;

    state_t            st_d, st_q;
    logic [N_COMM-1:0] hit;
    logic              frame_bad;

    always_comb begin
        hit              = comm_en_i & comm_fault_i;
        frame_bad        = |(st_q.seen | hit);
        st_d             = st_q;
        st_d.rst_flag_n  = st_q.rst_flag_n | rst_clr_i;
        st_d.comm_flag_n = st_q.comm_flag_n & ~hit;
        st_d.seen        = st_q.seen | hit;
        if (frame_end_i) begin
            st_d.seen = '0;
            if (!frame_bad) st_d.comm_flag_n = '1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{rst_flag_n: 1'b0, comm_flag_n: '1, seen: '0};
        else         st_q <= st_d;
    end

    assign rst_flag_no  = st_q.rst_flag_n;
    assign comm_flag_no = st_q.comm_flag_n;

    AST_COMM_FAULT_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> ((comm_flag_no & $past(comm_en_i & comm_fault_i)) == '0)); // R6
    AST_CLEAN_FRAME_RECOVERS: assert property (@(posedge clk_i) disable iff (!rst_ni) (frame_end_i && st_q.seen == '0 && (comm_en_i & comm_fault_i) == '0) |=> (comm_flag_no == '1)); // R7
    AST_RST_FLAG_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni) (!rst_flag_no && !rst_clr_i) |=> !rst_flag_no); // R8
endmodule

// File: rtl/ffb_conv_counters.sv
module ffb_conv_counters #(
    parameter int N = 3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [N-1:0]   done_i,
    output logic [2*N-1:0] cnt_o
);
    typedef struct packed {
        logic [N-1:0][1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            st_d.cnt[i] = st_q.cnt[i] + {1'b0, done_i[i]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{cnt: '0};
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    for (genvar g = 0; g < N; g++) begin : g_lane_chk
        AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> (cnt_o[2*g +: 2] == 2'($past(cnt_o[2*g +: 2]) + {1'b0, $past(done_i[g])}))); // R9
    end
endmodule

// File: rtl/fault_flag_bank.sv
module fault_flag_bank
    import ffb_pkg::*;
#(
    parameter int N_SUP  = 8,
    parameter int N_CLK  = 3,
    parameter int N_DIG  = 4,
    parameter int N_CONV = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [N_SUP-1:0]  sup_fault_i,
    input  logic [N_CLK-1:0]  clk_fault_i,
    input  logic [N_DIG-1:0]  dig_fault_i,
    input  logic [N_COMM-1:0] comm_fault_i,
    input  logic              frame_end_i,
    input  logic [N_CONV-1:0] conv_done_i
);
    localparam int CNT_W = 2 * N_CONV;

    typedef struct packed {
        logic [N_SUP-1:0]  en_sup;
        logic [N_CLK-1:0]  en_clk;
        logic [N_DIG-1:0]  en_dig;
        logic [N_SUP-1:0]  dg_sup;
        logic [N_CLK-1:0]  dg_clk;
        logic [N_DIG-1:0]  dg_dig;
        logic [N_COMM-1:0] comm_en;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic [N_SUP-1:0]  clr_sup, sup_flag_n;
    logic [N_CLK-1:0]  clr_clk, clk_flag_n;
    logic [N_DIG-1:0]  clr_dig, dig_flag_n;
    logic [N_COMM-1:0] comm_flag_n;
    logic              rst_flag_n;
    logic              rst_clr;
    logic [CNT_W-1:0]  cnt;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^wr_data_i;

    // Configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_SUP_EN:  cfg_d.en_sup  = wr_data_i[N_SUP-1:0];
                A_CLK_EN:  cfg_d.en_clk  = wr_data_i[N_CLK-1:0];
                A_DIG_EN:  cfg_d.en_dig  = wr_data_i[N_DIG-1:0];
                A_SUP_DG:  cfg_d.dg_sup  = wr_data_i[N_SUP-1:0];
                A_CLK_DG:  cfg_d.dg_clk  = wr_data_i[N_CLK-1:0];
                A_DIG_DG:  cfg_d.dg_dig  = wr_data_i[N_DIG-1:0];
                A_COMM_EN: cfg_d.comm_en = wr_data_i[N_COMM-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    // Write-one-to-clear masks
    always_comb begin
        clr_sup = '0;
        clr_clk = '0;
        clr_dig = '0;
        rst_clr = 1'b0;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_GEN:    rst_clr = wr_data_i[0];
                A_SUP_ST: clr_sup = wr_data_i[N_SUP-1:0];
                A_CLK_ST: clr_clk = wr_data_i[N_CLK-1:0];
                A_DIG_ST: clr_dig = wr_data_i[N_DIG-1:0];
                default: ;
            endcase
        end
    end

    ffb_sticky_group #(.W(N_SUP)) u_sup (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (cfg_q.en_sup),
        .diag_i (cfg_q.dg_sup),
        .fault_i(sup_fault_i),
        .clr_i  (clr_sup),
        .flag_no(sup_flag_n)
    );

    ffb_sticky_group #(.W(N_CLK)) u_clk (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (cfg_q.en_clk),
        .diag_i (cfg_q.dg_clk),
        .fault_i(clk_fault_i),
        .clr_i  (clr_clk),
        .flag_no(clk_flag_n)
    );

    ffb_sticky_group #(.W(N_DIG)) u_dig (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (cfg_q.en_dig),
        .diag_i (cfg_q.dg_dig),
        .fault_i(dig_fault_i),
        .clr_i  (clr_dig),
        .flag_no(dig_flag_n)
    );

    ffb_comm_group u_comm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .comm_en_i   (cfg_q.comm_en),
        .comm_fault_i(comm_fault_i),
        .frame_end_i (frame_end_i),
        .rst_clr_i   (rst_clr),
        .rst_flag_no (rst_flag_n),
        .comm_flag_no(comm_flag_n)
    );

    ffb_conv_counters #(.N(N_CONV)) u_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .done_i(conv_done_i),
        .cnt_o (cnt)
    );

    // Read mux
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_GEN:     rd_data_o[N_COMM:0]    = {comm_flag_n, rst_flag_n};
            A_CONV:    rd_data_o[CNT_W-1:0]   = cnt;
            A_SUP_ST:  rd_data_o[N_SUP-1:0]   = sup_flag_n;
            A_CLK_ST:  rd_data_o[N_CLK-1:0]   = clk_flag_n;
            A_DIG_ST:  rd_data_o[N_DIG-1:0]   = dig_flag_n;
            A_SUP_EN:  rd_data_o[N_SUP-1:0]   = cfg_q.en_sup;
            A_CLK_EN:  rd_data_o[N_CLK-1:0]   = cfg_q.en_clk;
            A_DIG_EN:  rd_data_o[N_DIG-1:0]   = cfg_q.en_dig;
            A_SUP_DG:  rd_data_o[N_SUP-1:0]   = cfg_q.dg_sup;
            A_CLK_DG:  rd_data_o[N_CLK-1:0]   = cfg_q.dg_clk;
            A_DIG_DG:  rd_data_o[N_DIG-1:0]   = cfg_q.dg_dig;
            A_COMM_EN: rd_data_o[N_COMM-1:0]  = cfg_q.comm_en;
            default: ;
        endcase
    end

    AST_CFG_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni) !wr_en_i |=> $stable(cfg_q)); // R10
endmodule

// File: tb/fault_flag_bank_tb_top.sv
`timescale 1ns/10ps
module fault_flag_bank_tb_top;
    localparam int NS = 8;
    localparam int NC = 3;
    localparam int ND = 4;
    localparam int NV = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [3:0]    rd_addr = '0;
    logic [15:0]   rd_data;
    logic [NS-1:0] sup_f = '0;
    logic [NC-1:0] clk_f = '0;
    logic [ND-1:0] dig_f = '0;
    logic [3:0]    comm_f = '0;
    logic          frame_end = 1'b0;
    logic [NV-1:0] done = '0;

    always #5 clk = ~clk;

    fault_flag_bank #(.N_SUP(NS), .N_CLK(NC), .N_DIG(ND), .N_CONV(NV)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .sup_fault_i (sup_f),
        .clk_fault_i (clk_f),
        .dig_fault_i (dig_f),
        .comm_fault_i(comm_f),
        .frame_end_i (frame_end),
        .conv_done_i (done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference state: latched faults are active high here
    logic [15:0] m_en [3];
    logic [15:0] m_dg [3];
    logic [15:0] m_lat[3];
    logic        m_rlat;
    logic [3:0]  m_clat, m_seen, m_cen;
    logic [1:0]  m_cnt[NV];

    function automatic logic [15:0] mask(int c);
        case (c)
            0:       return 16'h00FF;
            1:       return 16'h0007;
            default: return 16'h000F;
        endcase
    endfunction

    function automatic logic [15:0] flt(int c);
        case (c)
            0:       return 16'(sup_f);
            1:       return 16'(clk_f);
            default: return 16'(dig_f);
        endcase
    endfunction

    function automatic logic [15:0] exp_word(int a);
        logic [15:0] w;
        w = '0;
        case (a)
            0:       w[4:0] = {~m_clat, ~m_rlat};
            1:       for (int i = 0; i < NV; i++) w[2*i +: 2] = m_cnt[i];
            2, 3, 4: w = ~m_lat[a-2] & mask(a-2);
            5, 6, 7: w = m_en[a-5];
            8, 9, 10: w = m_dg[a-8];
            11:      w[3:0] = m_cen;
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic string req_of(int a);
        case (a)
            0:       return "R8/R6/R7";
            1:       return "R9";
            2, 3, 4: return "R1/R2/R3/R4/R5";
            default: return "R10";
        endcase
    endfunction

    task automatic check_all();
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a);
            #0.2;
            n_cmp++;
            if (rd_data !== exp_word(a)) begin
                n_bad++;
                $display("FAIL %s addr %0d actual %h expected %h", req_of(a), a, rd_data, exp_word(a));
            end
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_en[c] = '0; m_dg[c] = '0; m_lat[c] = '0;
        end
        m_rlat = 1'b1; m_clat = '0; m_seen = '0; m_cen = '0;
        for (int i = 0; i < NV; i++) m_cnt[i] = '0;
    endtask

    // One clock: predict from current inputs, clock, then compare every word
    task automatic step();
        logic [15:0] nl[3];
        logic [15:0] eff, clr;
        logic [3:0]  ceff, nclat, nseen;
        logic        nr;
        for (int c = 0; c < 3; c++) begin
            eff   = m_en[c] & (flt(c) | m_dg[c]) & mask(c);
            clr   = (wr_en && wr_addr == 4'(2 + c)) ? wr_data : 16'h0;
            nl[c] = (eff | (m_lat[c] & ~clr)) & mask(c);
        end
        nr   = m_rlat & !(wr_en && wr_addr == 4'd0 && wr_data[0]);
        ceff = m_cen & comm_f;
        if (frame_end) begin
            nclat = ((m_seen | ceff) == 4'h0) ? 4'h0 : (m_clat | ceff);
            nseen = 4'h0;
        end else begin
            nclat = m_clat | ceff;
            nseen = m_seen | ceff;
        end
        @(posedge clk);
        for (int c = 0; c < 3; c++) m_lat[c] = nl[c];
        m_rlat = nr; m_clat = nclat; m_seen = nseen;
        for (int i = 0; i < NV; i++) m_cnt[i] = m_cnt[i] + 2'(done[i]);
        if (wr_en) begin
            if (wr_addr >= 4'd5 && wr_addr <= 4'd7)  m_en[int'(wr_addr) - 5] = wr_data & mask(int'(wr_addr) - 5);
            if (wr_addr >= 4'd8 && wr_addr <= 4'd10) m_dg[int'(wr_addr) - 8] = wr_data & mask(int'(wr_addr) - 8);
            if (wr_addr == 4'd11) m_cen = wr_data[3:0];
        end
        #1;
        check_all();
    endtask

    task automatic wr(int a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        check_all();  // R1, R8 reset values
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] e, d;
        reset_dut();

        // R8: writing 0 leaves the reset indicator low, writing 1 clears it
        wr(0, 16'h0000);
        wr(0, 16'h0001);

        // R2 R3 R4 R5: sweep enables, diagnostics, faults and clear masks
        for (int k = 0; k < 48; k++) begin
            e = 16'(k * 59) ^ 16'(k << 3);
            d = (k % 4 == 0) ? (e >> 1) ^ 16'h00A5 : 16'h0000;
            for (int c = 0; c < 3; c++) wr(5 + c, e ^ 16'(c * 16'h55));
            for (int c = 0; c < 3; c++) wr(8 + c, d ^ 16'(c * 3));
            sup_f = NS'(k * 7); clk_f = NC'(k); dig_f = ND'(k * 3);
            step();
            for (int c = 0; c < 3; c++) wr(2 + c, 16'hFFFF);  // fault beats clear
            sup_f = '0; clk_f = '0; dig_f = '0;
            wr(2, 16'h0000);                                   // zero write ignored
            for (int c = 0; c < 3; c++) wr(8 + c, 16'h0000);
            for (int c = 0; c < 3; c++) wr(2 + c, 16'(k * 11)); // partial clear
            step();
        end
        for (int c = 0; c < 3; c++) wr(2 + c, 16'hFFFF);

        // R6 R7: frame-by-frame link faults
        wr(11, 16'h000F);
        for (int f = 0; f < 24; f++) begin
            if (f == 12) wr(11, 16'h0005);
            for (int j = 0; j < 4; j++) begin
                comm_f    = 4'h0;
                if (j == 1 && f % 3 == 0) comm_f = 4'(f) ^ 4'h9;
                if (j == 3 && f % 5 == 1) comm_f = 4'h2 | 4'(f);
                frame_end = (j == 3);
                wr_en     = (j == 2 && f % 4 == 2);
                wr_addr   = 4'd0;
                wr_data   = 16'h001E;
                step();
                wr_en = 1'b0; wr_data = '0;
            end
            comm_f = '0; frame_end = 1'b0;
        end

        // R9: counter wrap under varied completion patterns
        for (int t = 0; t < 40; t++) begin
            done = NV'(t ^ (t >> 1));
            step();
        end
        done = '0;

        // R8 R1: latch state, then reset again mid-run
        wr(5, 16'h00FF);
        sup_f = 8'h3C;
        step();
        sup_f = '0;
        reset_dut();
        step();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule